// File: doc/BRIEF.md
# ADC Calibration Mode Sequencer

This block sequences the calibration runs of a sigma-delta converter. A 3-bit mode code, written with a one-cycle strobe, selects one of several jobs. Normal conversion is the default. Self calibration measures the shorted inputs and then the reference. A two-step system calibration takes the zero point and the full-scale point from the analog input in two separate commands. System offset calibration takes the zero point from the analog input and the full-scale point from the reference. Background calibration interleaves internal calibration conversions with normal conversions for as long as the mode is held.

The sequencer steers the modulator input multiplexer and pulses a digital-filter reset. It counts the filter's output-ready strobes and latches the filter data into the zero-scale and full-scale coefficient registers at the right strobe. It then reports the captured span, so downstream arithmetic can derive the gain without a divider inside this block. An active-low data-ready line stays high while a calibration is running. A falling edge on the synchronisation input also resets the filter and restarts whatever sequence is in progress.

Top module: `adc_cal_sequencer`

## Requirements
- R1: After reset, drdy_n is 1, in_sel is 0 (analog input), flt_rst is 0, res_invalid is 0, and both coefficients and the span are 0. in_sel never takes the value 3.
- R2: A cycle with mode_wr high makes flt_rst high for exactly the next cycle. drdy_n is 1 from the cycle after that until the new sequence completes.
- R3: Code 001 (self): in_sel is 1 (shorted inputs) for 4 strobes, and zs_coef takes the data of the 4th. in_sel is then 2 (reference) for 4 strobes, and fs_coef takes the data of the 8th. in_sel is then 0, and drdy_n falls after the 9th strobe.
- R4: Code 100 (system offset) follows R3 with in_sel 0 instead of 1 during the first 4 strobes.
- R5: Code 010 captures zs_coef from the 4th strobe on in_sel 0, and code 011 captures fs_coef the same way. Each drops drdy_n after that 4th strobe.
- R6: Code 010 issued after any full-scale capture moves fs_coef by the same amount as zs_coef, which leaves the span unchanged.
- R7: Code 101 (background) repeats a 6-strobe round until another code is written: strobe 1 on in_sel 1 captures zs_coef, strobes 2–5 are on in_sel 0, and strobe 6 on in_sel 2 captures fs_coef. Each round's 5th strobe is a result and drops drdy_n. res_invalid is 1 after the first result that comes before any full-scale capture, and 0 after later results.
- R8: Codes 000, 110 and 111 select normal conversion: in_sel 0, coefficients held, and drdy_n falls after the first strobe.
- R9: span equals fs_coef − zs_coef (two's complement, DATA_W+2 bits), or twice that when bipolar was 1 at the last mode write. It follows the coefficients with one cycle of delay.
- R10: A falling edge of sync_n pulses flt_rst the next cycle and restarts the running sequence from its first step with drdy_n high. A completed one-shot calibration is not repeated.
- R11: zs_coef and fs_coef change only on the cycle after a flt_rdy strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | One-cycle strobe that loads mode_code and bipolar |
| mode_code | input | 3 | Job select (see R3–R8) |
| bipolar | input | 1 | Bipolar coding for the span |
| sync_n | input | 1 | Falling edge resets the filter and restarts the sequence |
| flt_rdy | input | 1 | Filter output-ready strobe |
| flt_data | input | DATA_W | Filter raw result |
| in_sel | output | 2 | Modulator input: 0 analog, 1 shorted, 2 reference |
| flt_rst | output | 1 | Digital filter reset pulse |
| zs_coef | output | DATA_W | Zero-scale reading |
| fs_coef | output | DATA_W | Full-scale reading |
| span | output | DATA_W+2 | Signed captured span |
| drdy_n | output | 1 | Active-low data ready |
| res_invalid | output | 1 | Latest background result lacks a full-scale point |

## Verification
Some properties are checked by the bound assertions on every cycle. A mode write or a falling sync edge produces a filter-reset pulse, and a command drives data-ready high. The coefficients stay frozen except after a strobe. The input selector never leaves its three legal codes. The bench scenarios are the only place the strobe-counted behaviour can be observed: at which strobe each capture lands, the background round order and its invalid flag, the offset-only update that keeps the slope, the doubling of the span in bipolar mode, and restarts by sync partway through a sequence.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

  typedef enum logic [1:0] {
    SEL_AIN   = 2'd0,
    SEL_SHORT = 2'd1,
    SEL_REF   = 2'd2
  } sel_e;

  typedef enum logic [2:0] {
    RUN_NORM = 3'd0,
    RUN_SELF = 3'd1,
    RUN_SYSZ = 3'd2,
    RUN_SYSF = 3'd3,
    RUN_OFFS = 3'd4,
    RUN_BACK = 3'd5
  } run_e;

  function automatic run_e decode_code(input logic [2:0] code);
    case (code)
      3'b001:  return RUN_SELF;
      3'b010:  return RUN_SYSZ;
      3'b011:  return RUN_SYSF;
      3'b100:  return RUN_OFFS;
      3'b101:  return RUN_BACK;
      default: return RUN_NORM;
    endcase
  endfunction

endpackage

// File: rtl/cal_cmd_front.sv
module cal_cmd_front
  import adc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr,
  input  logic [2:0] mode_code,
  input  logic       bipolar,
  input  logic       sync_n,
  output logic       flt_rst,
  output logic       start_cmd,
  output logic       start_sync,
  output run_e       run_req,
  output logic       bip_q
);

  logic sync_q;
  logic sync_fall;

  assign sync_fall = sync_q & ~sync_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q     <= 1'b1;
      flt_rst    <= 1'b0;
      start_cmd  <= 1'b0;
      start_sync <= 1'b0;
      run_req    <= RUN_NORM;
      bip_q      <= 1'b0;
    end else begin
      sync_q     <= sync_n;
      flt_rst    <= mode_wr | sync_fall;
      start_cmd  <= mode_wr;
      start_sync <= sync_fall & ~mode_wr;
      if (mode_wr) begin
        run_req <= decode_code(mode_code);
        bip_q   <= bipolar;
      end
    end
  end

endmodule

// File: rtl/cal_step_ctrl.sv
module cal_step_ctrl
  import adc_cal_pkg::*;
#(
  parameter int PH_LEN   = 4,
  parameter int BG_ROUND = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start_cmd,
  input  logic start_sync,
  input  run_e run_req,
  input  logic flt_rdy,
  output sel_e in_sel,
  output logic drdy_n,
  output logic res_invalid,
  output logic cap_zs,
  output logic cap_fs,
  output logic keep_slope
);

  localparam int SEQ_LONG = 2 * PH_LEN + 1;
  localparam int CNT_TOP  = (SEQ_LONG > BG_ROUND) ? SEQ_LONG : BG_ROUND;
  localparam int CNT_W    = $clog2(CNT_TOP + 1);

  localparam logic [CNT_W-1:0] C_ZS   = CNT_W'(PH_LEN - 1);
  localparam logic [CNT_W-1:0] C_FS   = CNT_W'(2 * PH_LEN - 1);
  localparam logic [CNT_W-1:0] C_END  = CNT_W'(SEQ_LONG - 1);
  localparam logic [CNT_W-1:0] C_PH   = CNT_W'(PH_LEN);
  localparam logic [CNT_W-1:0] C_PH2  = CNT_W'(2 * PH_LEN);
  localparam logic [CNT_W-1:0] C_BREF = CNT_W'(BG_ROUND - 1);
  localparam logic [CNT_W-1:0] C_BPUB = CNT_W'(BG_ROUND - 2);

  run_e             cur, cur_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             fs_seen;
  logic             go, last, pub_bg, one_long, one_short;

  function automatic sel_e sel_of(input run_e m, input logic [CNT_W-1:0] c);
    case (m)
      RUN_SELF: return (c < C_PH) ? SEL_SHORT : (c < C_PH2) ? SEL_REF : SEL_AIN;
      RUN_OFFS: return (c < C_PH) ? SEL_AIN   : (c < C_PH2) ? SEL_REF : SEL_AIN;
      RUN_BACK: return (c == '0) ? SEL_SHORT : (c == C_BREF) ? SEL_REF : SEL_AIN;
      default:  return SEL_AIN;
    endcase
  endfunction

  assign go         = flt_rdy & ~start_cmd & ~start_sync;
  assign one_long   = (cur == RUN_SELF) || (cur == RUN_OFFS);
  assign one_short  = (cur == RUN_SYSZ) || (cur == RUN_SYSF);
  assign keep_slope = (cur == RUN_SYSZ);

  assign cap_zs = go && (((one_long || cur == RUN_SYSZ) && cnt == C_ZS) ||
                         (cur == RUN_BACK && cnt == '0));
  assign cap_fs = go && ((one_long && cnt == C_FS) ||
                         (cur == RUN_SYSF && cnt == C_ZS) ||
                         (cur == RUN_BACK && cnt == C_BREF));
  assign last   = go && ((one_long && cnt == C_END) || (one_short && cnt == C_ZS));
  assign pub_bg = go && (cur == RUN_BACK) && (cnt == C_BPUB);

  always_comb begin
    cur_n = cur;
    cnt_n = cnt;
    if (start_cmd) begin
      cur_n = run_req;
      cnt_n = '0;
    end else if (start_sync) begin
      cnt_n = '0;
    end else if (go) begin
      if (last) begin
        cur_n = RUN_NORM;
        cnt_n = '0;
      end else if (cur == RUN_BACK) begin
        cnt_n = (cnt == C_BREF) ? '0 : cnt + 1'b1;
      end else if (cur != RUN_NORM) begin
        cnt_n = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur         <= RUN_NORM;
      cnt         <= '0;
      fs_seen     <= 1'b0;
      drdy_n      <= 1'b1;
      res_invalid <= 1'b0;
      in_sel      <= SEL_AIN;
    end else begin
      cur    <= cur_n;
      cnt    <= cnt_n;
      in_sel <= sel_of(cur_n, cnt_n);
      if (start_cmd) begin
        drdy_n      <= 1'b1;
        fs_seen     <= 1'b0;
        res_invalid <= 1'b0;
      end else if (start_sync) begin
        drdy_n <= 1'b1;
      end else if (go) begin
        if (cur == RUN_NORM || last || pub_bg) drdy_n <= 1'b0;
        if (pub_bg) res_invalid <= ~fs_seen;
        if (cap_fs && cur == RUN_BACK) fs_seen <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cal_coef_bank.sv
module cal_coef_bank #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_zs,
  input  logic              cap_fs,
  input  logic              keep_slope,
  input  logic              bip,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] zs_q,
  output logic [DATA_W-1:0] fs_q,
  output logic [DATA_W+1:0] span_q
);

  localparam int SPAN_W = DATA_W + 2;

  logic              have_fs;
  logic signed [SPAN_W-1:0] diff;

  assign diff = $signed({2'b00, fs_q}) - $signed({2'b00, zs_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      zs_q    <= '0;
      fs_q    <= '0;
      have_fs <= 1'b0;
      span_q  <= '0;
    end else begin
      span_q <= bip ? (diff <<< 1) : diff;
      if (cap_zs) begin
        zs_q <= data;
        if (keep_slope && have_fs) fs_q <= fs_q + (data - zs_q);
      end
      if (cap_fs) begin
        fs_q    <= data;
        have_fs <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
  import adc_cal_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int PH_LEN   = 4,
  parameter int BG_ROUND = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [2:0]        mode_code,
  input  logic              bipolar,
  input  logic              sync_n,
  input  logic              flt_rdy,
  input  logic [DATA_W-1:0] flt_data,
  output logic [1:0]        in_sel,
  output logic              flt_rst,
  output logic [DATA_W-1:0] zs_coef,
  output logic [DATA_W-1:0] fs_coef,
  output logic [DATA_W+1:0] span,
  output logic              drdy_n,
  output logic              res_invalid
);

  logic start_cmd, start_sync, bip_q;
  logic cap_zs, cap_fs, keep_slope;
  run_e run_req;
  sel_e sel;

  cal_cmd_front u_front (
    .clk        (clk),
    .rst        (rst),
    .mode_wr    (mode_wr),
    .mode_code  (mode_code),
    .bipolar    (bipolar),
    .sync_n     (sync_n),
    .flt_rst    (flt_rst),
    .start_cmd  (start_cmd),
    .start_sync (start_sync),
    .run_req    (run_req),
    .bip_q      (bip_q)
  );

  cal_step_ctrl #(.PH_LEN(PH_LEN), .BG_ROUND(BG_ROUND)) u_steps (
    .clk         (clk),
    .rst         (rst),
    .start_cmd   (start_cmd),
    .start_sync  (start_sync),
    .run_req     (run_req),
    .flt_rdy     (flt_rdy),
    .in_sel      (sel),
    .drdy_n      (drdy_n),
    .res_invalid (res_invalid),
    .cap_zs      (cap_zs),
    .cap_fs      (cap_fs),
    .keep_slope  (keep_slope)
  );

  cal_coef_bank #(.DATA_W(DATA_W)) u_coef (
    .clk        (clk),
    .rst        (rst),
    .cap_zs     (cap_zs),
    .cap_fs     (cap_fs),
    .keep_slope (keep_slope),
    .bip        (bip_q),
    .data       (flt_data),
    .zs_q       (zs_coef),
    .fs_q       (fs_coef),
    .span_q     (span)
  );

  assign in_sel = sel;

endmodule

// File: rtl/adc_cal_sequencer_chk.sv
module adc_cal_sequencer_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_wr,
  input logic              sync_n,
  input logic              flt_rdy,
  input logic [1:0]        in_sel,
  input logic              flt_rst,
  input logic [DATA_W-1:0] zs_coef,
  input logic [DATA_W-1:0] fs_coef,
  input logic              drdy_n
);

  // R2
  cmd_filter_reset_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> flt_rst);

  // R2
  cmd_busy_flag_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> ##1 drdy_n);

  // R10
  sync_filter_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_n) |=> flt_rst);

  // R11
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flt_rdy |=> $stable(zs_coef));

  // R11
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flt_rdy |=> $stable(fs_coef));

  // R1
  sel_legal_chk: assert property (@(posedge clk) disable iff (rst)
    in_sel != 2'd3);

endmodule

bind adc_cal_sequencer adc_cal_sequencer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mode_wr (mode_wr),
  .sync_n  (sync_n),
  .flt_rdy (flt_rdy),
  .in_sel  (in_sel),
  .flt_rst (flt_rst),
  .zs_coef (zs_coef),
  .fs_coef (fs_coef),
  .drdy_n  (drdy_n)
);

// File: tb/adc_cal_sequencer_test.sv
`timescale 1ns/1ps
module adc_cal_sequencer_test;

  localparam int W = 24;
  localparam longint MASK = (64'd1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_wr = 1'b0;
  logic [2:0]   mode_code = 3'd0;
  logic         bipolar = 1'b0;
  logic         sync_n = 1'b1;
  logic         flt_rdy = 1'b0;
  logic [W-1:0] flt_data = '0;
  logic [1:0]   in_sel;
  logic         flt_rst;
  logic [W-1:0] zs_coef, fs_coef;
  logic [W+1:0] span;
  logic         drdy_n, res_invalid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  adc_cal_sequencer #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_code(mode_code),
    .bipolar(bipolar), .sync_n(sync_n), .flt_rdy(flt_rdy), .flt_data(flt_data),
    .in_sel(in_sel), .flt_rst(flt_rst), .zs_coef(zs_coef), .fs_coef(fs_coef),
    .span(span), .drdy_n(drdy_n), .res_invalid(res_invalid)
  );

  // ---------------- behavioural reference model ----------------
  typedef struct { int sel; int cap; bit pub; } step_t;
  step_t  plan[$];
  int     m_cur = 0, m_req = 0, m_sel = 0;
  bit     m_bip = 0, m_drdy = 1, m_inv = 0, m_fsseen = 0, m_hasfs = 0;
  bit     m_frst = 0, m_stc = 0, m_sts = 0, m_prev_sync = 1;
  longint m_zs = 0, m_fs = 0, m_span = 0;

  function automatic int code_to_job(input logic [2:0] c);
    case (c)
      3'b001: return 1; 3'b010: return 2; 3'b011: return 3;
      3'b100: return 4; 3'b101: return 5; default: return 0;
    endcase
  endfunction

  task automatic add(input int s, input int c, input bit p);
    step_t t;
    t.sel = s; t.cap = c; t.pub = p;
    plan.push_back(t);
  endtask

  task automatic build(input int job);
    plan.delete();
    case (job)
      1, 4: begin
        for (int i = 0; i < 4; i++) add((job == 1) ? 1 : 0, (i == 3) ? 1 : 0, 0);
        for (int i = 0; i < 4; i++) add(2, (i == 3) ? 2 : 0, 0);
        add(0, 0, 1);
      end
      2, 3: for (int i = 0; i < 4; i++) add(0, (i == 3) ? job - 1 : 0, i == 3);
      5: begin
        add(1, 1, 0);
        for (int i = 0; i < 4; i++) add(0, 0, i == 3);
        add(2, 2, 0);
      end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (rst) begin
      plan.delete();
      m_cur = 0; m_req = 0; m_sel = 0; m_bip = 0; m_drdy = 1; m_inv = 0;
      m_fsseen = 0; m_hasfs = 0; m_frst = 0; m_stc = 0; m_sts = 0;
      m_prev_sync = 1; m_zs = 0; m_fs = 0; m_span = 0;
    end else begin
      longint nspan;
      bit fall;
      nspan = m_bip ? 2 * (m_fs - m_zs) : (m_fs - m_zs);
      fall = m_prev_sync && !sync_n;
      if (m_stc || m_sts) begin
        if (m_stc) begin m_cur = m_req; m_fsseen = 0; m_inv = 0; end
        build(m_cur);
        m_drdy = 1;
      end else if (flt_rdy) begin
        if (plan.size() == 0) m_drdy = 0;
        else begin
          step_t s;
          s = plan.pop_front();
          if (s.cap == 1) begin
            if (m_cur == 2 && m_hasfs) m_fs = (m_fs + longint'(flt_data) - m_zs) & MASK;
            m_zs = longint'(flt_data);
          end
          if (s.cap == 2) begin
            m_fs = longint'(flt_data); m_hasfs = 1;
            if (m_cur == 5) m_fsseen = 1;
          end
          if (s.pub) begin
            m_drdy = 0;
            if (m_cur == 5) m_inv = !m_fsseen;
          end
          if (plan.size() == 0) begin
            if (m_cur == 5) build(5); else m_cur = 0;
          end
        end
      end
      m_sel = (plan.size() != 0) ? plan[0].sel : 0;
      m_frst = mode_wr | fall;
      m_stc = mode_wr;
      m_sts = fall && !mode_wr;
      if (mode_wr) begin m_req = code_to_job(mode_code); m_bip = bipolar; end
      m_prev_sync = sync_n;
      m_span = nspan;
    end
  end

  function automatic string job_tag(input int j);
    case (j)
      1: return "R3"; 2, 3: return "R5"; 4: return "R4"; 5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(job_tag(m_cur), "in_sel", longint'(in_sel), m_sel);
      chk(job_tag(m_cur), "drdy_n", longint'(drdy_n), longint'(m_drdy));
      chk("R7", "res_invalid", longint'(res_invalid), longint'(m_inv));
      chk("R2", "flt_rst", longint'(flt_rst), longint'(m_frst));
      chk("R11", "zs_coef", longint'(zs_coef), m_zs);
      chk("R11", "fs_coef", longint'(fs_coef), m_fs);
      chk("R9", "span", longint'($signed(span)), m_span);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired (all requirements)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic cmd(input logic [2:0] c, input logic b);
    @(negedge clk); mode_code = c; bipolar = b; mode_wr = 1'b1;
    @(negedge clk); mode_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe(input logic [W-1:0] d);
    @(negedge clk); flt_rdy = 1'b1; flt_data = d;
    @(negedge clk); flt_rdy = 1'b0; flt_data = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic strobes(input int n, input logic [W-1:0] base);
    for (int i = 0; i < n; i++) strobe(base + W'(i * 16));
  endtask

  initial begin
    longint span_keep;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "reset drdy_n", longint'(drdy_n), 1);
    chk("R1", "reset in_sel", longint'(in_sel), 0);
    chk("R1", "reset span", longint'(span), 0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);

    // R8 normal conversion
    cmd(3'b000, 1'b0);
    strobes(3, 24'h001000);
    chk("R8", "normal drdy low", longint'(drdy_n), 0);

    // R3 self calibration, unipolar
    cmd(3'b001, 1'b0);
    chk("R2", "busy after command", longint'(drdy_n), 1);
    strobes(4, 24'h000100);
    chk("R3", "zs after phase 1", longint'(zs_coef), longint'(24'h000130));
    strobes(4, 24'h300000);
    chk("R3", "in_sel settle", longint'(in_sel), 0);
    strobes(1, 24'h123456);
    chk("R3", "done drdy", longint'(drdy_n), 0);
    strobes(2, 24'h000777);

    // R5 two-step system calibration
    cmd(3'b010, 1'b0);
    strobes(4, 24'h000200);
    cmd(3'b011, 1'b0);
    strobes(4, 24'h500000);
    chk("R5", "fs after step 2", longint'(fs_coef), longint'(24'h500030));
    span_keep = longint'($signed(span));

    // R6 offset-only update keeps span
    cmd(3'b010, 1'b0);
    strobes(4, 24'h000800);
    chk("R6", "zs moved", longint'(zs_coef), longint'(24'h000830));
    chk("R6", "span kept", longint'($signed(span)), span_keep);

    // R10 sync mid self calibration restarts it
    cmd(3'b001, 1'b0);
    strobes(6, 24'h000050);
    @(negedge clk); sync_n = 1'b0;
    @(negedge clk); sync_n = 1'b1;
    @(negedge clk);
    chk("R10", "restart in_sel", longint'(in_sel), 1);
    chk("R10", "restart drdy", longint'(drdy_n), 1);
    strobes(9, 24'h000060);
    chk("R10", "done after restart", longint'(drdy_n), 0);
    @(negedge clk); sync_n = 1'b0;
    @(negedge clk); sync_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "no repeat in_sel", longint'(in_sel), 0);
    strobes(1, 24'h000001);

    // R4 + R9 system offset, bipolar span doubling
    cmd(3'b100, 1'b1);
    chk("R4", "first phase analog", longint'(in_sel), 0);
    strobes(4, 24'h001000);
    strobes(4, 24'h201000);
    strobes(1, 24'h000000);
    chk("R9", "bipolar span", longint'($signed(span)),
        2 * (longint'(24'h201030) - longint'(24'h001030)));

    // R7 background calibration
    cmd(3'b101, 1'b0);
    strobes(5, 24'h000400);
    chk("R7", "first result invalid", longint'(res_invalid), 1);
    strobes(6, 24'h600000);
    chk("R7", "second result valid", longint'(res_invalid), 0);
    strobes(13, 24'h010000);

    // R8 reserved codes act as normal
    cmd(3'b111, 1'b0);
    span_keep = longint'(zs_coef);
    strobes(3, 24'h0ABCDE);
    chk("R8", "code 111 zs held", longint'(zs_coef), span_keep);
    cmd(3'b110, 1'b1);
    strobes(2, 24'h0BCDEF);
    chk("R8", "code 110 in_sel", longint'(in_sel), 0);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule